// File: doc/BRIEF.md
# Programmable-Trigger Interrupt Controller

This block gathers 32 raw interrupt request lines into one active-high interrupt line for a processor. Software programs each source through a small word-addressed register port. A mode bit selects whether the source is sensed by edge or by level. A polarity bit selects which edge or which level counts as active.

Every raw line first passes through a two-stage synchronizer. An edge source latches a pending request when its synchronized value moves to the active state. That request stays pending until software writes a one to the matching bit of the clear register. A level source is pending for as long as its input sits at the active level. Pending requests are masked by a per-source enable and can be read back as a status word. The interrupt output is a registered OR of that status word.

The usual handler flow is: read the status word, service the sources it shows, then acknowledge them through the clear register. A level source that is still asserted after its acknowledge returns on the next cycle. An edge that arrives while its source is disabled is held until the source is enabled again.

Top module: `irq_ctrl`

## Requirements
- R1: Register map with word offsets on `bus_addr`: 0x00 status (read-only, writes ignored), 0x04 enable, 0x08 clear (write-only, reads as zero), 0x0C trigger mode, 0x10 polarity. A write happens on a clock edge with `bus_sel`=1 and `bus_wr`=1. A read is combinational: with `bus_sel`=1 and `bus_wr`=0, `bus_rdata` shows the addressed register, and it is zero otherwise. Bit i of each register belongs to source i, for 32 sources.
- R2: After reset: enable is 0x00000000, mode is 0x00000000 (all level), polarity is 0xFFFFFFFF (all active-low), status is 0 and `irq_out` is 0.
- R3: A mode bit of 1 makes its source edge-sensed. A mode bit of 0 makes it level-sensed.
- R4: A polarity bit of 1 selects active-low level or falling edge. A polarity bit of 0 selects active-high level or rising edge.
- R5: An `irq_in` change sampled at clock edge k shows in status after edge k+2, because of two synchronizer stages and one pending register.
- R6: Status equals pending AND enable. A disabled source never shows in status and never drives `irq_out`.
- R7: Writing 1 to a clear bit drops that source's pending request. Clear bits written as 0 have no effect.
- R8: A clear of a level source whose input is still active makes its status bit 0 for exactly one cycle, after which it returns.
- R9: A latched edge request stays pending until it is cleared, including while its enable bit is 0. It shows in status as soon as the source is enabled.
- R10: `irq_out` equals the OR of the status bits of the previous cycle.
- R11: When a new active edge is detected in the same cycle as a clear of that source, the request stays pending.
- R12: A level source stops being pending once its synchronized input leaves the active level, without any clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_in | input | 32 | Raw interrupt requests, asynchronous |
| irq_out | output | 1 | Interrupt to the processor, active high |

## Verification
The hardest state to reach from the ports is a clear write that lands in the exact cycle where a fresh edge is detected on a source that is already pending. A fixed input delay separates the pin from the detector. Directed stimulus therefore drives a falling edge, waits two clocks and then issues the clear, so that both events meet. A latched edge on a disabled source is also built on purpose and then revealed by enabling the source. A long seeded random phase then mixes sparse input toggles with writes to every register. Its results are compared against a cycle-level bench model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC   = 32;
    localparam int DW     = 32;
    localparam int AW     = 5;
    localparam int SYNC_N = 2;

    typedef enum logic [AW-1:0] {
        OFS_STAT = 5'h00,
        OFS_EN   = 5'h04,
        OFS_CLR  = 5'h08,
        OFS_MODE = 5'h0C,
        OFS_POL  = 5'h10
    } reg_ofs_e;

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] mode;
        logic [NSRC-1:0] pol;
    } irq_cfg_t;

    typedef struct packed {
        logic          sel;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } bus_req_t;

    function automatic logic is_write(bus_req_t r, reg_ofs_e ofs);
        return r.sel && r.wr && (r.addr == ofs);
    endfunction

    function automatic logic [NSRC-1:0] active_of(logic [NSRC-1:0] v,
                                                  logic [NSRC-1:0] pol);
        return v ^ pol;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync
    import irqc_pkg::*;
#(
    parameter int N      = NSRC,
    parameter int STAGES = SYNC_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] cur,
    output logic [N-1:0] old
);
    logic [N-1:0] stage_q [STAGES];
    logic [N-1:0] old_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stage_q[s] <= '0;
            else if (s == 0)
                stage_q[s] <= raw;
            else
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) old_q <= '0;
        else     old_q <= stage_q[STAGES-1];
    end

    assign cur = stage_q[STAGES-1];
    assign old = old_q;
endmodule

// File: rtl/irqc_trig.sv
module irqc_trig
    import irqc_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cur,
    input  logic [N-1:0] old,
    input  logic [N-1:0] mode,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] act_now;
    logic [N-1:0] act_old;

    assign act_now = active_of(cur, pol);
    assign act_old = active_of(old, pol);

    for (genvar i = 0; i < N; i++) begin : g_src
        logic p_q;
        logic p_d;

        always_comb begin
            if (mode[i])
                p_d = (p_q & ~clr[i]) | (act_now[i] & ~act_old[i]);
            else
                p_d = act_now[i] & ~clr[i];
        end

        always_ff @(posedge clk) begin
            if (rst) p_q <= 1'b0;
            else     p_q <= p_d;
        end

        assign pend[i] = p_q;

        // edge request survives any cycle without a clear of its bit
        p_edge_hold_r9: assert property (@(posedge clk) disable iff (rst)
            (mode[i] && p_q && !clr[i]) |=> p_q);

        // a level clear always opens a one-cycle gap
        p_level_gap_r8: assert property (@(posedge clk) disable iff (rst)
            (!mode[i] && clr[i]) |=> !p_q);
    end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  bus_req_t        req,
    input  logic [NSRC-1:0] status,
    output irq_cfg_t        cfg,
    output logic [NSRC-1:0] clr,
    output logic [DW-1:0]   rdata
);
    irq_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.en   <= '0;
            cfg_q.mode <= '0;
            cfg_q.pol  <= '1;
        end else begin
            if (is_write(req, OFS_EN))   cfg_q.en   <= req.wdata[NSRC-1:0];
            if (is_write(req, OFS_MODE)) cfg_q.mode <= req.wdata[NSRC-1:0];
            if (is_write(req, OFS_POL))  cfg_q.pol  <= req.wdata[NSRC-1:0];
        end
    end

    assign cfg = cfg_q;
    assign clr = is_write(req, OFS_CLR) ? req.wdata[NSRC-1:0] : '0;

    always_comb begin
        rdata = '0;
        if (req.sel && !req.wr) begin
            case (req.addr)
                OFS_STAT: rdata = status;
                OFS_EN:   rdata = cfg_q.en;
                OFS_MODE: rdata = cfg_q.mode;
                OFS_POL:  rdata = cfg_q.pol;
                default:  rdata = '0;
            endcase
        end
    end

    p_en_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !is_write(req, OFS_EN) |=> $stable(cfg_q.en));
    p_mode_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !is_write(req, OFS_MODE) |=> $stable(cfg_q.mode));
    p_pol_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !is_write(req, OFS_POL) |=> $stable(cfg_q.pol));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] irq_in,
    output logic            irq_out
);
    bus_req_t        req;
    irq_cfg_t        cfg;
    logic [NSRC-1:0] clr;
    logic [NSRC-1:0] cur;
    logic [NSRC-1:0] old;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] status;
    logic            irq_q;

    assign req = '{sel: bus_sel, wr: bus_wr, addr: bus_addr, wdata: bus_wdata};

    irqc_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .status (status),
        .cfg    (cfg),
        .clr    (clr),
        .rdata  (bus_rdata)
    );

    irqc_sync #(.N(NSRC), .STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .raw (irq_in),
        .cur (cur),
        .old (old)
    );

    irqc_trig #(.N(NSRC)) u_trig (
        .clk  (clk),
        .rst  (rst),
        .cur  (cur),
        .old  (old),
        .mode (cfg.mode),
        .pol  (cfg.pol),
        .clr  (clr),
        .pend (pend)
    );

    assign status = pend & cfg.en;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |status;
    end

    assign irq_out = irq_q;
endmodule

// File: tb/sim_irq_ctrl.sv
`timescale 1ns/100ps
module sim_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        b_sel = 1'b0;
    logic        b_wr = 1'b0;
    logic [4:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] rdata;
    logic [31:0] irq_in = '0;
    logic        irq_out;

    int n_run = 0;
    int n_fail = 0;

    logic [31:0] m_en, m_mode, m_pol, m_s1, m_s2, m_prev, m_pend;
    logic        m_irq;

    always #2.5 clk = ~clk;

    irq_ctrl u0 (
        .clk(clk), .rst(rst), .bus_sel(b_sel), .bus_wr(b_wr),
        .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] next_pend(logic [31:0] clr);
        logic [31:0] an, ao;
        an = m_s2 ^ m_pol;
        ao = m_prev ^ m_pol;
        return (m_mode & ((m_pend & ~clr) | (an & ~ao))) | (~m_mode & an & ~clr);
    endfunction

    task automatic model_edge();
        logic [31:0] clr;
        if (rst) begin
            m_en = '0; m_mode = '0; m_pol = '1;
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_irq = 1'b0;
        end else begin
            clr = (b_sel && b_wr && b_addr == 5'h08) ? b_wdata : '0;
            m_irq  = |(m_pend & m_en);
            m_pend = next_pend(clr);
            m_prev = m_s2; m_s2 = m_s1; m_s1 = irq_in;
            if (b_sel && b_wr) begin
                case (b_addr)
                    5'h04: m_en   = b_wdata;
                    5'h0C: m_mode = b_wdata;
                    5'h10: m_pol  = b_wdata;
                    default: ;
                endcase
            end
        end
    endtask

    // one clock: model follows the edge, then status and irq_out are compared
    task automatic tick(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        b_sel = 1'b1; b_wr = 1'b0; b_addr = 5'h00;
        #0.5;
        if (!rst) begin
            chk(tag, rdata, m_pend & m_en);
            chk(tag, {31'b0, irq_out}, {31'b0, m_irq});
        end
        b_sel = 1'b0;
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d, string tag);
        b_sel = 1'b1; b_wr = 1'b1; b_addr = a; b_wdata = d;
        tick(tag);
        b_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        b_sel = 1'b1; b_wr = 1'b0; b_addr = a;
        #0.5;
        d = rdata;
        b_sel = 1'b0;
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    initial begin
        #500000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd24681));
        ticks(3, "R2");
        rst = 1'b0;
        tick("R2");
        // reset state
        rd(5'h04, v); chk("R2 enable", v, 32'h0);
        rd(5'h0C, v); chk("R2 mode", v, 32'h0);
        rd(5'h10, v); chk("R2 polarity", v, 32'hFFFF_FFFF);
        rd(5'h00, v); chk("R2 status", v, 32'h0);
        chk("R2 irq_out", {31'b0, irq_out}, 32'h0);

        // register map
        wr(5'h00, 32'hFFFF_FFFF, "R1");
        rd(5'h00, v); chk("R1 status write ignored", v, 32'h0);
        wr(5'h04, 32'hA5A5_0000, "R1");
        rd(5'h04, v); chk("R1 enable readback", v, 32'hA5A5_0000);
        rd(5'h08, v); chk("R1 clear reads zero", v, 32'h0);

        // default active-low level with all inputs low
        wr(5'h04, 32'hFFFF_FFFF, "R4");
        ticks(3, "R4");
        rd(5'h00, v); chk("R4 active-low level", v, 32'hFFFF_FFFF);
        chk("R10 irq_out high", {31'b0, irq_out}, 32'h1);

        // active-high level, latency of a single source
        wr(5'h10, 32'h0, "R4");
        tick("R12");
        rd(5'h00, v); chk("R12 level released", v, 32'h0);
        irq_in[3] = 1'b1;
        tick("R5"); tick("R5");
        rd(5'h00, v); chk("R5 not yet visible", v & 32'h8, 32'h0);
        tick("R5");
        rd(5'h00, v); chk("R5 visible after k+2", v & 32'h8, 32'h8);
        tick("R10");
        chk("R10 irq one cycle later", {31'b0, irq_out}, 32'h1);

        // clear of an asserted level source
        wr(5'h08, 32'h8, "R8");
        rd(5'h00, v); chk("R8 gap", v & 32'h8, 32'h0);
        tick("R8");
        rd(5'h00, v); chk("R8 returns", v & 32'h8, 32'h8);
        irq_in[3] = 1'b0;
        ticks(3, "R12");
        rd(5'h00, v); chk("R12 drop without clear", v & 32'h8, 32'h0);

        // edge source latched while disabled
        wr(5'h04, 32'h0, "R6");
        wr(5'h0C, 32'h0000_0060, "R3");
        wr(5'h10, 32'h0000_0040, "R4");
        irq_in[5] = 1'b1; tick("R3");
        irq_in[5] = 1'b0; ticks(4, "R6");
        chk("R6 disabled no irq", {31'b0, irq_out}, 32'h0);
        wr(5'h04, 32'hFFFF_FFFF, "R9");
        rd(5'h00, v); chk("R9 edge kept while disabled", v, 32'h20);
        wr(5'h08, 32'hFFFF_FFDF, "R7");
        rd(5'h00, v); chk("R7 zero bits no effect", v, 32'h20);
        wr(5'h08, 32'h20, "R7");
        rd(5'h00, v); chk("R7 clear drops", v, 32'h0);

        // falling edge on bit 6, then clear meeting a new edge
        irq_in[6] = 1'b1; ticks(4, "R4");
        irq_in[6] = 1'b0; ticks(4, "R4");
        rd(5'h00, v); chk("R4 falling edge", v, 32'h40);
        irq_in[6] = 1'b1; ticks(4, "R11");
        irq_in[6] = 1'b0; tick("R11"); tick("R11");
        wr(5'h08, 32'h40, "R11");
        rd(5'h00, v); chk("R11 edge beats clear", v, 32'h40);
        wr(5'h08, 32'h40, "R7");

        // seeded random phase against the model
        for (int c = 0; c < 4000; c++) begin
            int op;
            irq_in = irq_in ^ ($urandom() & $urandom() & $urandom());
            op = $urandom_range(0, 11);
            case (op)
                0: wr(5'h04, $urandom(), "R6");
                1: wr(5'h0C, $urandom(), "R3");
                2: wr(5'h10, $urandom(), "R4");
                3, 4: wr(5'h08, $urandom(), "R7");
                5: wr(5'h00, $urandom(), "R1");
                6: begin
                    rd(5'h04, v); chk("R1 enable", v, m_en);
                    rd(5'h0C, v); chk("R1 mode", v, m_mode);
                    rd(5'h10, v); chk("R1 polarity", v, m_pol);
                    tick("R6");
                end
                default: tick("R10");
            endcase
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule